// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block produces the gate pulse train for a flyback converter that switches at the valleys of the drain ringing. Each switching cycle has three phases. An on-phase is ended by the current-sense trip once a blanking window has passed, or by a maximum on-time. A minimum off-phase follows, and its length depends on the load. The last phase is a hunt for the first valley, which has a fallback timeout. All analog sensing is done elsewhere: the block sees a sampled feedback code, a trip flag, a valley flag and an enable from the protection logic.

At light load the feedback code falls, and the block stretches the minimum off-time linearly so that the switching frequency drops. The green-mode region has hysteresis on the feedback code. A parameter selects between a low-frequency timing set and a high-frequency timing set. All times are given in nanoseconds and converted to clock cycles at elaboration as ceil(ns * CLK_MHZ / 1000).

Top module: `qr_valley_sequencer`

## Requirements
- R1: While reset is asserted, and while `en_i` is low, `gate_o` stays low; `valley_i` and `cs_trip_i` then have no effect.
- R2: The base minimum off-time is 8000 ns with HF_VARIANT=0 and 3000 ns with HF_VARIANT=1. With `valley_i` held high and the feedback code out of green mode, the gate stays low for exactly that cycle count plus one.
- R3: A valley flag that is seen only during the minimum off-time does not start a cycle. The cycle then starts on the timeout of R4.
- R4: If no valley arrives, the next pulse starts after the minimum off-time plus a timeout of 9000 ns (HF_VARIANT=0) or 5000 ns (HF_VARIANT=1). The low time is exactly the sum of the two cycle counts.
- R5: Let Ex = FB_GREEN + FB_HYST. In green mode the minimum off-time is TMIN + ((Ex - fb) * K) >> SLOPE_SH, where K = floor(((TMAX - TMIN) << SLOPE_SH) / (Ex - FB_SAT)). For fb <= FB_SAT it is exactly TMAX, with TMAX at 38000 ns (HF_VARIANT=0) or 13000 ns (HF_VARIANT=1).
- R6: Green mode is entered when fb < FB_GREEN and left when fb >= FB_GREEN + FB_HYST. In between, the previous mode is kept. Out of green mode the minimum off-time is TMIN.
- R7: During the first LEB_NS of a pulse, the trip is masked. If the trip is held high from the start, the pulse lasts exactly LEB cycles + 1.
- R8: After blanking, a trip sampled high at the end of the k-th high cycle makes that the last high cycle, so the pulse is k cycles long.
- R9: A pulse never exceeds the maximum on-time of 45000 ns. With no trip it lasts exactly that cycle count.
- R10: A feedback code at or below FB_ZERO produces no pulse; the cycle restarts with a new off-phase. FB_ZERO + 1 still produces pulses.
- R11: When `en_i` is sampled low, the gate is low after that clock edge. After `en_i` is sampled high again, the gate rises on edge TMIN + 2 (valley present, not in green mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable from the protection logic |
| fb_code_i | input | FB_W | Unsigned feedback code from the converter |
| cs_trip_i | input | 1 | Current-sense peak trip flag |
| valley_i | input | 1 | Valley detected on the auxiliary winding |
| gate_o | output | 1 | Gate drive request |

## Verification
The assertions watch properties that hold on every cycle. They check that the gate is low after enable is removed, that no pulse exceeds the on-time cap, that no pulse ends inside blanking unless enable dropped, that no low interval is shorter than the base minimum off-time, that no pulse starts from a code at or below the zero-duty level, and that the computed off-time stays within its two bounds. Other behaviour can only be shown by the bench's scenarios, which measure exact run lengths against the requirements: the exact green-mode ramp values, the hysteresis memory between the two thresholds, valley flags ignored during the off-time, the timeout fallback, a trip that arrives mid-pulse, and the timing of the high-frequency variant.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_OFFMIN = 2'd1,
      SEQ_HUNT   = 2'd2,
      SEQ_ON     = 2'd3
   } seq_state_e;

   function automatic int ns_to_cycles(input int ns, input int clk_mhz);
      return (ns * clk_mhz + 999) / 1000;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/qr_span_counter.sv
module qr_span_counter #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);
   // clears to zero, otherwise counts up and holds at all ones
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_o <= '0;
      else if (clr_i)          cnt_o <= '0;
      else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/qr_toff_calc.sv
module qr_toff_calc #(
   parameter int FB_W     = 10,
   parameter int FB_SAT   = 240,
   parameter int FB_GREEN = 420,
   parameter int FB_HYST  = 20,
   parameter int TOFF_MIN = 32,
   parameter int TOFF_MAX = 152,
   parameter int SLOPE_SH = 12,
   parameter int OUT_W    = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [FB_W-1:0]  fb_code_i,
   output logic [OUT_W-1:0] toff_o
);
   localparam int     EW      = FB_W + 1;
   localparam int     FB_EXIT = FB_GREEN + FB_HYST;
   localparam int     SPAN    = FB_EXIT - FB_SAT;
   localparam int     RISE    = TOFF_MAX - TOFF_MIN;
   localparam longint K       = (longint'(RISE) << SLOPE_SH) / longint'(SPAN);
   localparam int     K_W     = (K < 2) ? 1 : $clog2(K + 1);
   localparam int     PROD_W  = EW + K_W;
   localparam logic [K_W-1:0] K_VEC = K_W'(K);

   logic              green_q;
   logic              in_green;
   logic [EW-1:0]     deficit;
   logic [PROD_W-1:0] prod;
   logic [OUT_W-1:0]  toff_d;

   // hysteresis: enter below FB_GREEN, leave at FB_EXIT or above
   always_comb begin
      in_green = (fb_code_i < FB_W'(FB_GREEN)) ||
                 (green_q && ({1'b0, fb_code_i} < EW'(FB_EXIT)));
      deficit  = EW'(FB_EXIT) - {1'b0, fb_code_i};
      prod     = PROD_W'(deficit) * PROD_W'(K_VEC);
      if (!in_green)                         toff_d = OUT_W'(TOFF_MIN);
      else if (fb_code_i <= FB_W'(FB_SAT))   toff_d = OUT_W'(TOFF_MAX);
      else toff_d = OUT_W'(TOFF_MIN) + OUT_W'(prod >> SLOPE_SH);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         green_q <= 1'b0;
         toff_o  <= OUT_W'(TOFF_MIN);
      end else begin
         green_q <= in_green;
         toff_o  <= toff_d;
      end
   end

   assert_toff_bounds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (toff_o >= OUT_W'(TOFF_MIN)) && (toff_o <= OUT_W'(TOFF_MAX)));

   assert_exit_green_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, fb_code_i} >= EW'(FB_EXIT)) |=> (toff_o == OUT_W'(TOFF_MIN)));
endmodule

// File: rtl/qr_valley_sequencer.sv
module qr_valley_sequencer
   import qr_seq_pkg::*;
#(
   parameter int CLK_MHZ    = 125,
   parameter bit HF_VARIANT = 1'b0,
   parameter int FB_W       = 10,
   parameter int FB_ZERO    = 200,
   parameter int FB_SAT     = 240,
   parameter int FB_GREEN   = 420,
   parameter int FB_HYST    = 20,
   parameter int SLOPE_SH   = 12,
   parameter int LEB_NS     = 625,
   parameter int TON_MAX_NS = 45000
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic [FB_W-1:0] fb_code_i,
   input  logic            cs_trip_i,
   input  logic            valley_i,
   output logic            gate_o
);
   localparam int TOFF_MIN_NS = HF_VARIANT ? 3000  : 8000;
   localparam int TOFF_MAX_NS = HF_VARIANT ? 13000 : 38000;
   localparam int TMO_NS      = HF_VARIANT ? 5000  : 9000;

   localparam int TOFF_MIN_CYC = ns_to_cycles(TOFF_MIN_NS, CLK_MHZ);
   localparam int TOFF_MAX_CYC = ns_to_cycles(TOFF_MAX_NS, CLK_MHZ);
   localparam int TMO_CYC      = ns_to_cycles(TMO_NS, CLK_MHZ);
   localparam int LEB_CYC      = ns_to_cycles(LEB_NS, CLK_MHZ);
   localparam int TON_MAX_CYC  = ns_to_cycles(TON_MAX_NS, CLK_MHZ);
   localparam int MAX_CYC      = max2(max2(TOFF_MAX_CYC, TMO_CYC), TON_MAX_CYC);
   localparam int CNT_W        = $clog2(MAX_CYC + 1);

   generate
      if (FB_SAT <= FB_ZERO || FB_GREEN <= FB_SAT || FB_HYST < 0 ||
          FB_GREEN + FB_HYST >= (1 << FB_W)) begin : g_bad_fb
         $error("feedback thresholds must satisfy ZERO < SAT < GREEN and fit FB_W");
      end
      if (TOFF_MIN_CYC < 1 || TMO_CYC < 1 || LEB_CYC >= TON_MAX_CYC) begin : g_bad_time
         $error("timing parameters give an empty phase");
      end
   endgenerate

   seq_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] toff_now, toff_q;
   logic             cnt_clr, toff_ld;
   logic             fb_live;

   qr_span_counter #(.W(CNT_W)) u_phase_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr),
      .cnt_o  (cnt)
   );

   qr_toff_calc #(
      .FB_W     (FB_W),
      .FB_SAT   (FB_SAT),
      .FB_GREEN (FB_GREEN),
      .FB_HYST  (FB_HYST),
      .TOFF_MIN (TOFF_MIN_CYC),
      .TOFF_MAX (TOFF_MAX_CYC),
      .SLOPE_SH (SLOPE_SH),
      .OUT_W    (CNT_W)
   ) u_toff (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fb_code_i (fb_code_i),
      .toff_o    (toff_now)
   );

   assign fb_live = fb_code_i > FB_W'(FB_ZERO);

   always_comb begin
      st_d    = st_q;
      cnt_clr = 1'b0;
      toff_ld = 1'b0;
      if (!en_i) begin
         st_d    = SEQ_IDLE;
         cnt_clr = 1'b1;
      end else begin
         unique case (st_q)
            SEQ_IDLE: begin
               st_d    = SEQ_OFFMIN;
               cnt_clr = 1'b1;
               toff_ld = 1'b1;
            end
            SEQ_OFFMIN: begin
               if (cnt == toff_q - 1'b1) begin
                  st_d    = SEQ_HUNT;
                  cnt_clr = 1'b1;
               end
            end
            SEQ_HUNT: begin
               if (valley_i || cnt == CNT_W'(TMO_CYC - 1)) begin
                  cnt_clr = 1'b1;
                  if (fb_live) st_d = SEQ_ON;
                  else begin
                     st_d    = SEQ_OFFMIN;
                     toff_ld = 1'b1;
                  end
               end
            end
            SEQ_ON: begin
               if ((cs_trip_i && cnt >= CNT_W'(LEB_CYC)) ||
                   cnt == CNT_W'(TON_MAX_CYC - 1)) begin
                  st_d    = SEQ_OFFMIN;
                  cnt_clr = 1'b1;
                  toff_ld = 1'b1;
               end
            end
            default: st_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= SEQ_IDLE;
         toff_q <= CNT_W'(TOFF_MIN_CYC);
      end else begin
         st_q <= st_d;
         if (toff_ld) toff_q <= toff_now;
      end
   end

   assign gate_o = (st_q == SEQ_ON);

   // run-length observers used only by the properties below
   logic [15:0] hi_run, lo_run;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= gate_o ? ((hi_run != '1) ? hi_run + 1'b1 : hi_run) : '0;
         lo_run <= gate_o ? '0 : ((lo_run != '1) ? lo_run + 1'b1 : lo_run);
      end
   end

   assert_gate_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !gate_o);

   assert_on_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_o |-> (hi_run < 16'(TON_MAX_CYC)));

   assert_blank_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(gate_o) && $past(en_i)) |-> (hi_run > 16'(LEB_CYC)));

   assert_min_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_o) |-> (lo_run > 16'(TOFF_MIN_CYC)));

   assert_zero_duty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_o) |-> ($past(fb_code_i) > FB_W'(FB_ZERO)));
endmodule

// File: tb/qr_valley_sequencer_tb_top.sv
module qr_valley_sequencer_tb_top;
   // bench-side timing at CLK_MHZ = 4
   localparam int TMIN_A = 32, TMAX_A = 152, TMO_A = 36, LEB = 3, TON = 180;
   localparam int TMIN_H = 12, TMO_H = 20;
   localparam int EXIT_LVL = 440, SAT_LVL = 240;
   localparam longint KB = (longint'(TMAX_A - TMIN_A) << 12) / (EXIT_LVL - SAT_LVL);

   typedef struct { bit hi; int len; string tag; } run_t;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, trip = 1'b0, valley = 1'b0;
   logic [9:0] fb = 10'd500;
   logic gate_a, gate_h;
   int checks = 0, errors = 0;
   run_t exp_q[$];
   logic prev_g = 1'b0;
   int run_len = 0;

   always #4 clk = ~clk;

   qr_valley_sequencer #(.CLK_MHZ(4), .HF_VARIANT(1'b0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fb_code_i(fb),
      .cs_trip_i(trip), .valley_i(valley), .gate_o(gate_a));

   qr_valley_sequencer #(.CLK_MHZ(4), .HF_VARIANT(1'b1)) dut_h_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fb_code_i(fb),
      .cs_trip_i(trip), .valley_i(valley), .gate_o(gate_h));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int ramp_toff(input int f);
      if (f <= SAT_LVL) return TMAX_A;
      return TMIN_A + int'((longint'(EXIT_LVL - f) * KB) >>> 12);
   endfunction

   // monitor: compare each finished run against the scoreboard
   always @(negedge clk) begin
      run_t e;
      if (!rst_n) begin
         prev_g  = 1'b0;
         run_len = 0;
      end else if (gate_a != prev_g) begin
         if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            check(e.hi == prev_g && e.len == run_len, e.tag, run_len, e.len);
         end
         prev_g  = gate_a;
         run_len = 1;
      end else begin
         run_len++;
      end
   end

   // driver: let the inputs settle for one cycle, then score the next low/high pair
   task automatic expect_cycle(input int lo, input int hi, input bit vpulse, input string tag);
      @(negedge gate_a);
      @(negedge gate_a);
      @(negedge clk); #1;
      exp_q.push_back('{1'b0, lo, tag});
      exp_q.push_back('{1'b1, hi, tag});
      if (vpulse) begin
         repeat (4) @(negedge clk);
         valley = 1'b1;
         repeat (10) @(negedge clk);
         valley = 1'b0;
      end
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic count_to_rise(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!gate_a);
   endtask

   task automatic low_run_h(output int n);
      @(negedge gate_h);
      @(negedge gate_h);
      @(negedge clk);
      n = 1;
      while (!gate_h) begin
         @(negedge clk);
         if (!gate_h) n++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      valley = 1'b1;
      trip   = 1'b1;
      repeat (3) @(negedge clk);
      check(gate_a == 1'b0, "R1 reset", gate_a, 0);
      rst_n = 1'b1;
      n = 0;
      repeat (50) begin
         @(negedge clk);
         if (gate_a) n++;
      end
      check(n == 0, "R1 disabled ignores valley", n, 0);

      en = 1'b1;
      count_to_rise(n);
      check(n == TMIN_A + 2, "R11 first pulse after enable", n, TMIN_A + 2);

      expect_cycle(TMIN_A + 1, LEB + 1, 1'b0, "R2+R7 valley held, trip held");
      trip = 1'b0;
      expect_cycle(TMIN_A + 1, TON, 1'b0, "R9 on-time cap");
      valley = 1'b0;
      expect_cycle(TMIN_A + TMO_A, TON, 1'b0, "R4 timeout");
      expect_cycle(TMIN_A + TMO_A, TON, 1'b1, "R3 early valley ignored");

      valley = 1'b1;
      trip   = 1'b1;
      fb = 10'd430;
      expect_cycle(TMIN_A + 1, LEB + 1, 1'b0, "R6 above entry level stays normal");
      fb = 10'd410;
      expect_cycle(ramp_toff(410) + 1, LEB + 1, 1'b0, "R5 ramp at 410");
      fb = 10'd430;
      expect_cycle(ramp_toff(430) + 1, LEB + 1, 1'b0, "R6 hysteresis keeps green");
      fb = 10'd450;
      expect_cycle(TMIN_A + 1, LEB + 1, 1'b0, "R6 exit level restores minimum");
      fb = 10'd340;
      expect_cycle(ramp_toff(340) + 1, LEB + 1, 1'b0, "R5 ramp at 340");
      fb = 10'd300;
      expect_cycle(ramp_toff(300) + 1, LEB + 1, 1'b0, "R5 ramp at 300");
      fb = 10'd241;
      expect_cycle(ramp_toff(241) + 1, LEB + 1, 1'b0, "R5 ramp at 241");
      fb = 10'd230;
      expect_cycle(TMAX_A + 1, LEB + 1, 1'b0, "R5 saturation");
      fb = 10'd201;
      expect_cycle(TMAX_A + 1, LEB + 1, 1'b0, "R10 one above zero level");

      fb = 10'd200;
      repeat (10) @(negedge clk);
      n = 0;
      repeat (400) begin
         @(negedge clk);
         if (gate_a) n++;
      end
      check(n == 0, "R10 zero level gives no pulse", n, 0);

      fb   = 10'd500;
      trip = 1'b0;
      @(posedge gate_a);
      n = 0;
      while (n < 20) begin
         @(negedge clk);
         if (gate_a) n++;
      end
      trip = 1'b1;
      @(negedge clk);
      check(gate_a == 1'b0, "R8 trip after blanking ends pulse", gate_a, 0);

      trip = 1'b0;
      @(posedge gate_a);
      repeat (5) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check(gate_a == 1'b0, "R11 gate low after enable drop", gate_a, 0);
      n = 0;
      repeat (30) begin
         @(negedge clk);
         if (gate_a) n++;
      end
      check(n == 0, "R1 stays idle while disabled", n, 0);
      trip = 1'b1;
      en   = 1'b1;
      count_to_rise(n);
      check(n == TMIN_A + 2, "R11 full off-time after re-enable", n, TMIN_A + 2);

      low_run_h(n);
      check(n == TMIN_H + 1, "R2 high-frequency minimum off", n, TMIN_H + 1);
      valley = 1'b0;
      low_run_h(n);
      check(n == TMIN_H + TMO_H, "R4 high-frequency timeout", n, TMIN_H + TMO_H);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule